// File: doc/BRIEF.md
# Multiply-Accumulate Saturation Unit

This block conditions the products of a 32x32 multiplier and keeps four accumulators with their overflow status. Three product forms are offered: a signed integer product held to a 40-bit signed range, an unsigned integer product held to 40 bits, and a fractional product that drops the low 24 bits with optional round-half-to-even. When overflow-mode control is on, an overflowing product is replaced by a value large enough that the next accumulate is certain to leave the 48-bit range. The conditioned product sits in a product register. An accumulate operation adds that register into the selected accumulator.

Each accumulator holds a 48-bit architectural value plus 16 guard bits (64 bits stored), so that overflow past 48 bits stays visible until a saturate operation resolves it. The saturate operation checks range in one of three formats and, with overflow-mode control, clamps the value. A set-flags operation reports zero, negative, overflow and extension-overflow for one accumulator. A move operation copies an accumulator together with its per-accumulator overflow bit. The status bits are sticky. Software rewrites them through a status write port.

Every operation takes one clock and is acknowledged by a one-cycle done pulse. The format for saturate and for the extension check is chosen by two mode inputs. Fractional takes priority over signed, and unsigned is used when neither is set.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset every accumulator, the product register and the status register read zero, and done is low.
- R2: Done is high in exactly the cycle after a cycle with op_valid high (op_code 0..7, seven used, 7 has no effect), and low otherwise.
- R3: Multiply-signed (op_code 0) forms the signed 64-bit product. If the product fits 40-bit signed, it is stored unchanged. Otherwise V is set, and the stored product is 2^50 (non-negative) or -(2^50)-1 (negative) with mode_omc set, or the low 40 bits sign-extended with mode_omc clear.
- R4: Multiply-unsigned (op_code 1) forms the unsigned 64-bit product. Any set bit at or above bit 40 sets V and stores 2^50 with mode_omc set, or the low 40 bits with it clear.
- R5: Multiply-fractional (op_code 2) stores the unsigned product shifted right by 24. With mode_rnd set, a dropped 24-bit remainder above 0x800000 adds one, and exactly 0x800000 adds the quotient's bit 0. V is not touched.
- R6: Accumulate (op_code 3) adds the product register into accumulator acc_sel, modulo 2^64, and leaves status unchanged.
- R7: Signed saturate (op_code 4, mode_sgn=1, mode_frac=0) sets V when the accumulator differs from the sign extension of its bits 47:0. Whenever V is then set, it sets that accumulator's PAV bit. With mode_omc, it loads 0x7FFFFFFF, or 0xFFFFFFFF80000000 when bit 47 is one. Otherwise it loads the 48-bit sign extension.
- R8: Unsigned saturate (op_code 4, both format bits 0) sets V for nonzero bits 63:48 and sets PAV whenever V is set. With V and mode_omc, it loads 0 if the value exceeds 2^53, else 2^48-1. Otherwise it keeps bits 47:0 only.
- R9: Fractional saturate (op_code 4, mode_frac=1) applies the test and PAV rule of R7. With V and mode_omc, it loads 0x00007FFFFFFFFFFF, or 0xFFFF800000000000 when bit 47 is one.
- R10: Set-flags (op_code 5) sets Z when the accumulator is zero, else N when its bit 47 is one. It sets V when that accumulator's PAV bit is set.
- R11: Set-flags sets EV when bits 63:40 (mode_frac), bits 63:31 (mode_sgn only) are not all equal, or bits 63:32 are nonzero (unsigned).
- R12: Move (op_code 6) copies accumulator acc_src into acc_sel, and copies PAV bit acc_src into PAV bit acc_sel, whether set or clear.
- R13: Status layout is bit 0 N, bit 1 Z, bit 2 V, bit 3 EV, and bit 4+i the PAV bit of accumulator i. Bits stay set until stat_wr loads stat_wdata. In a cycle with both a write and an operation, the operation sees the written value and its settings are applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_code | input | 3 | Operation select |
| acc_sel | input | IW | Target accumulator |
| acc_src | input | IW | Source accumulator for move |
| opa | input | 32 | Multiplier operand A |
| opb | input | 32 | Multiplier operand B |
| mode_omc | input | 1 | Overflow-mode control |
| mode_rnd | input | 1 | Fractional rounding enable |
| mode_sgn | input | 1 | Signed format select |
| mode_frac | input | 1 | Fractional format select |
| stat_wr | input | 1 | Load the status register |
| stat_wdata | input | SW | Value for the status register |
| rd_sel | input | IW | Accumulator shown on rd_acc |
| done | output | 1 | One-cycle completion pulse |
| prod | output | 64 | Conditioned product register |
| rd_acc | output | 64 | Contents of accumulator rd_sel |
| stat | output | SW | Status register |

## Verification
A status write and an operation can fall in the same cycle. This matters most when the operation reads the sticky V bit or changes it. The bench sets V, then issues a signed saturate on an in-range negative accumulator together with a write of zero. The accumulator must come back unchanged and the status must be clear, where the same saturate without the write clamps the value and sets PAV. A second collision pairs the clearing write with an overflowing unsigned multiply, and the status must read V alone.

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int NACC = 4,
  localparam int IW = $clog2(NACC),
  localparam int SW = 4 + NACC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [IW-1:0] acc_sel,
  input  logic [IW-1:0] acc_src,
  input  logic [31:0]   opa,
  input  logic [31:0]   opb,
  input  logic          mode_omc,
  input  logic          mode_rnd,
  input  logic          mode_sgn,
  input  logic          mode_frac,
  input  logic          stat_wr,
  input  logic [SW-1:0] stat_wdata,
  input  logic [IW-1:0] rd_sel,
  output logic          done,
  output logic [63:0]   prod,
  output logic [63:0]   rd_acc,
  output logic [SW-1:0] stat
);
  localparam logic [2:0] OP_MULS = 3'd0, OP_MULU = 3'd1, OP_MULF = 3'd2,
                         OP_ACC = 3'd3, OP_SAT = 3'd4, OP_FLAGS = 3'd5, OP_MOVE = 3'd6;
  localparam int SB_N = 0, SB_Z = 1, SB_V = 2, SB_EV = 3, SB_PAV = 4;
  localparam logic [63:0] BIG = 64'd1 << 50;

  logic [63:0] acc [NACC];
  logic [63:0] ps, pu, cur, s48, sat_val, acc_wd, prod_nx;
  logic [39:0] fq;
  logic [23:0] frem;
  logic fup, ovf_s, ovf_u, ovf48, ovf_hi, ovf_sat, vnow, ev_f, acc_we, prod_we;
  logic [SW-1:0] base, stat_nx;

  assign ps = {{32{opa[31]}}, opa} * {{32{opb[31]}}, opb};
  assign pu = {32'd0, opa} * {32'd0, opb};
  assign ovf_s = !((ps[63:39] == '0) || (ps[63:39] == '1));
  assign ovf_u = |pu[63:40];
  assign fq = pu[63:24];
  assign frem = pu[23:0];
  assign fup = mode_rnd && ((frem > 24'h800000) || ((frem == 24'h800000) && fq[0]));

  assign cur = acc[acc_sel];
  assign s48 = {{16{cur[47]}}, cur[47:0]};
  assign ovf48 = (s48 != cur);
  assign ovf_hi = |cur[63:48];
  assign ovf_sat = (mode_frac || mode_sgn) ? ovf48 : ovf_hi;
  assign base = stat_wr ? stat_wdata : stat;
  assign vnow = base[SB_V] | ovf_sat;
  assign ev_f = mode_frac ? !((cur[63:40] == '0) || (cur[63:40] == '1)) :
                mode_sgn  ? !((cur[63:31] == '0) || (cur[63:31] == '1)) :
                            (cur[63:32] != '0);

  assign rd_acc = acc[rd_sel];
  assign prod_we = op_valid && (op_code <= OP_MULF);
  assign acc_we = op_valid && ((op_code == OP_ACC) || (op_code == OP_SAT) || (op_code == OP_MOVE));

  always_comb begin
    case (op_code)
      OP_MULS: prod_nx = !ovf_s ? ps : !mode_omc ? {{24{ps[39]}}, ps[39:0]} : (ps[63] ? ~BIG : BIG);
      OP_MULU: prod_nx = !ovf_u ? pu : mode_omc ? BIG : {24'd0, pu[39:0]};
      default: prod_nx = {24'd0, fq} + {63'd0, fup};
    endcase
  end

  always_comb begin
    if (!(vnow && mode_omc))
      sat_val = (mode_frac || mode_sgn) ? s48 : {16'd0, cur[47:0]};
    else if (mode_frac)
      sat_val = s48[63] ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
    else if (mode_sgn)
      sat_val = s48[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
    else
      sat_val = (cur > (64'd1 << 53)) ? 64'd0 : 64'h0000_FFFF_FFFF_FFFF;
  end

  always_comb begin
    case (op_code)
      OP_ACC:  acc_wd = cur + prod;
      OP_SAT:  acc_wd = sat_val;
      default: acc_wd = acc[acc_src];
    endcase
  end

  always_comb begin
    stat_nx = base;
    if (op_valid) begin
      case (op_code)
        OP_MULS: stat_nx[SB_V] = base[SB_V] | ovf_s;
        OP_MULU: stat_nx[SB_V] = base[SB_V] | ovf_u;
        OP_SAT: if (vnow) begin
          stat_nx[SB_V] = 1'b1;
          stat_nx[SB_PAV + int'(acc_sel)] = 1'b1;
        end
        OP_FLAGS: begin
          stat_nx[SB_Z]  = base[SB_Z] | (cur == '0);
          stat_nx[SB_N]  = base[SB_N] | ((cur != '0) && cur[47]);
          stat_nx[SB_V]  = base[SB_V] | base[SB_PAV + int'(acc_sel)];
          stat_nx[SB_EV] = base[SB_EV] | ev_f;
        end
        OP_MOVE: stat_nx[SB_PAV + int'(acc_sel)] = base[SB_PAV + int'(acc_src)];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NACC; i++) acc[i] <= '0;
      prod <= '0;
      stat <= '0;
      done <= 1'b0;
    end else begin
      done <= op_valid;
      stat <= stat_nx;
      if (prod_we) prod <= prod_nx;
      if (acc_we) acc[acc_sel] <= acc_wd;
    end
  end
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
  parameter int NACC = 4,
  localparam int IW = $clog2(NACC),
  localparam int SW = 4 + NACC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [IW-1:0] acc_sel,
  input logic          mode_omc,
  input logic          stat_wr,
  input logic [SW-1:0] stat,
  input logic [63:0]   prod,
  input logic          done
);
  p_done_high_r2: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> done);
  p_done_low_r2:  assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> !done);

  p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat[3:0] & $past(stat[3:0])) == $past(stat[3:0])));

  p_mulu_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && mode_omc) |=> ((prod == (64'd1 << 50)) || (prod[63:40] == 24'd0)));

  p_mulf_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> (prod[63:41] == 23'd0));

  p_sat_pav_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> (!stat[2] || stat[4 + int'($past(acc_sel))]));
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.NACC(NACC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel),
  .mode_omc(mode_omc), .stat_wr(stat_wr), .stat(stat), .prod(prod), .done(done)
);

// File: tb/sim_mac_sat_unit.sv
module sim_mac_sat_unit;
  logic clk = 1'b0;
  logic rst_n, op_valid, mode_omc, mode_rnd, mode_sgn, mode_frac, stat_wr, done;
  logic [2:0] op_code;
  logic [1:0] acc_sel, acc_src, rd_sel;
  logic [31:0] opa, opb;
  logic [7:0] stat_wdata, stat;
  logic [63:0] prod, rd_acc;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  mac_sat_unit u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .acc_src(acc_src), .opa(opa), .opb(opb), .mode_omc(mode_omc),
    .mode_rnd(mode_rnd), .mode_sgn(mode_sgn), .mode_frac(mode_frac), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .rd_sel(rd_sel), .done(done), .prod(prod), .rd_acc(rd_acc),
    .stat(stat));

  // {op, omc, rnd, a, b, expected product, expected V}
  localparam int NV = 18;
  localparam logic [133:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 32'h00000003, 32'hFFFFFFFB, 64'hFFFFFFFFFFFFFFF1, 1'b0},
    {3'd0, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h0004000000000000, 1'b1},
    {3'd0, 1'b1, 1'b0, 32'h80000000, 32'h7FFFFFFF, 64'hFFFBFFFFFFFFFFFF, 1'b1},
    {3'd0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'hFFFFFFFF00000001, 1'b1},
    {3'd0, 1'b0, 1'b0, 32'h00080000, 32'h00080000, 64'h0000004000000000, 1'b0},
    {3'd0, 1'b0, 1'b0, 32'h00100000, 32'h00080000, 64'hFFFFFF8000000000, 1'b1},
    {3'd0, 1'b0, 1'b0, 32'hFFF80000, 32'h00100000, 64'hFFFFFF8000000000, 1'b0},
    {3'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h000000FE00000001, 1'b1},
    {3'd1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0004000000000000, 1'b1},
    {3'd1, 1'b0, 1'b0, 32'h00010000, 32'h00010000, 64'h0000000100000000, 1'b0},
    {3'd1, 1'b0, 1'b0, 32'h00100000, 32'h00100000, 64'h0000000000000000, 1'b1},
    {3'd2, 1'b0, 1'b0, 32'h01800000, 32'h00000001, 64'h0000000000000001, 1'b0},
    {3'd2, 1'b0, 1'b1, 32'h01800000, 32'h00000001, 64'h0000000000000002, 1'b0},
    {3'd2, 1'b0, 1'b1, 32'h00800000, 32'h00000001, 64'h0000000000000000, 1'b0},
    {3'd2, 1'b0, 1'b1, 32'h00800001, 32'h00000001, 64'h0000000000000001, 1'b0},
    {3'd2, 1'b0, 1'b1, 32'h02800000, 32'h00000001, 64'h0000000000000002, 1'b0},
    {3'd2, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h000000FFFFFFFE00, 1'b0},
    {3'd2, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h000000FFFFFFFE00, 1'b0}
  };

  // md = {omc, rnd, sgn, frac}
  localparam logic [3:0] MD_U = 4'b0000, MD_UO = 4'b1000, MD_S = 4'b0010, MD_SO = 4'b1010,
                         MD_F = 4'b0001, MD_FO = 4'b1001;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [1:0] sel, input logic [1:0] src,
                       input logic [31:0] a, input logic [31:0] b, input logic [3:0] md,
                       input logic wr, input logic [7:0] wd);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_sel = sel; acc_src = src; opa = a; opb = b;
    {mode_omc, mode_rnd, mode_sgn, mode_frac} = md;
    stat_wr = wr; stat_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0; stat_wr = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] d);
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  task automatic op(input logic [2:0] c, input logic [1:0] sel, input logic [1:0] src,
                    input logic [3:0] md);
    do_op(c, sel, src, 32'd0, 32'd0, md, 1'b0, 8'd0);
  endtask

  task automatic acc_of(input logic [1:0] s, input string tag, input logic [63:0] exp);
    rd_sel = s;
    #1;
    chk(tag, rd_acc, exp);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_sel = '0; acc_src = '0; opa = '0; opb = '0;
    mode_omc = 1'b0; mode_rnd = 1'b0; mode_sgn = 1'b0; mode_frac = 1'b0;
    stat_wr = 1'b0; stat_wdata = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 stat", {56'd0, stat}, 64'd0);
    chk("R1 prod", prod, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    for (int s = 0; s < 4; s++) acc_of(2'(s), "R1 acc", 64'd0);

    for (int i = 0; i < NV; i++) begin
      string tg;
      logic [133:0] v;
      v = VEC[i];
      tg = (v[133:131] == 3'd0) ? "R3" : (v[133:131] == 3'd1) ? "R4" : "R5";
      wr_stat(8'h00);
      do_op(v[133:131], 2'd0, 2'd0, v[128:97], v[96:65], {v[130], v[129], 2'b00}, 1'b0, 8'd0);
      chk({tg, " product"}, prod, v[64:1]);
      chk({tg, " V"}, {63'd0, stat[2]}, {63'd0, v[0]});
    end

    // R2 done pulse
    op(3'd7, 2'd0, 2'd0, MD_U);
    chk("R2 done high", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R2 done low", {63'd0, done}, 64'd0);

    // R6 accumulate of forced value
    do_op(3'd1, 2'd0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, MD_UO, 1'b0, 8'd0);
    wr_stat(8'h00);
    op(3'd3, 2'd0, 2'd0, MD_U);
    acc_of(2'd0, "R6 acc", 64'h0004000000000000);
    chk("R6 stat", {56'd0, stat}, 64'h00);

    // R11 EV in unsigned and fractional formats
    wr_stat(8'h00); op(3'd5, 2'd0, 2'd0, MD_U);
    chk("R11 ev unsigned", {56'd0, stat}, 64'h08);
    wr_stat(8'h00); op(3'd5, 2'd0, 2'd0, MD_F);
    chk("R11 ev fractional", {56'd0, stat}, 64'h08);

    // R7 signed saturate with omc
    wr_stat(8'h00); op(3'd4, 2'd0, 2'd0, MD_SO);
    acc_of(2'd0, "R7 clamp", 64'h000000007FFFFFFF);
    chk("R7 stat", {56'd0, stat}, 64'h14);

    // R12 move with PAV set
    op(3'd6, 2'd1, 2'd0, MD_U);
    acc_of(2'd1, "R12 value", 64'h000000007FFFFFFF);
    chk("R12 pav copy", {56'd0, stat}, 64'h34);

    // R10 V follows cleared PAV, R11 signed EV clear
    wr_stat(8'h00); op(3'd5, 2'd1, 2'd0, MD_S);
    chk("R10 no V", {56'd0, stat}, 64'h00);

    // R10 negative, R11 signed vs unsigned
    do_op(3'd0, 2'd0, 2'd0, 32'd3, 32'hFFFFFFFB, MD_U, 1'b0, 8'd0);
    op(3'd3, 2'd2, 2'd0, MD_U);
    acc_of(2'd2, "R6 negative", 64'hFFFFFFFFFFFFFFF1);
    wr_stat(8'h00); op(3'd5, 2'd2, 2'd0, MD_S);
    chk("R10 N", {56'd0, stat}, 64'h01);
    op(3'd5, 2'd2, 2'd0, MD_U);
    chk("R11 ev unsigned neg", {56'd0, stat}, 64'h09);
    wr_stat(8'h00); op(3'd5, 2'd3, 2'd0, MD_U);
    chk("R10 Z", {56'd0, stat}, 64'h02);

    // R9 fractional saturate
    do_op(3'd0, 2'd0, 2'd0, 32'h80000000, 32'h7FFFFFFF, MD_UO, 1'b0, 8'd0);
    op(3'd3, 2'd2, 2'd0, MD_U);
    acc_of(2'd2, "R6 sum", 64'hFFFBFFFFFFFFFFF0);
    wr_stat(8'h00); op(3'd4, 2'd2, 2'd0, MD_FO);
    acc_of(2'd2, "R9 clamp", 64'hFFFF800000000000);
    chk("R9 stat", {56'd0, stat}, 64'h44);
    wr_stat(8'h00); op(3'd4, 2'd2, 2'd0, MD_FO);
    acc_of(2'd2, "R9 in range", 64'hFFFF800000000000);
    chk("R9 no V", {56'd0, stat}, 64'h00);

    // R8 unsigned saturate
    do_op(3'd1, 2'd0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, MD_UO, 1'b0, 8'd0);
    for (int k = 0; k < 9; k++) op(3'd3, 2'd3, 2'd0, MD_U);
    acc_of(2'd3, "R6 repeat", 64'h0024000000000000);
    wr_stat(8'h00); op(3'd4, 2'd3, 2'd0, MD_UO);
    acc_of(2'd3, "R8 above 2^53", 64'd0);
    chk("R8 stat", {56'd0, stat}, 64'h84);
    op(3'd3, 2'd3, 2'd0, MD_U);
    wr_stat(8'h00); op(3'd4, 2'd3, 2'd0, MD_UO);
    acc_of(2'd3, "R8 max", 64'h0000FFFFFFFFFFFF);
    op(3'd3, 2'd3, 2'd0, MD_U);
    wr_stat(8'h00); op(3'd4, 2'd3, 2'd0, MD_U);
    acc_of(2'd3, "R8 truncate", 64'h0000FFFFFFFFFFFF);
    chk("R8 trunc stat", {56'd0, stat}, 64'h84);
    wr_stat(8'h00); op(3'd4, 2'd3, 2'd0, MD_UO);
    chk("R8 in range", {56'd0, stat}, 64'h00);

    // R13 collision: clearing write beside saturate that would see sticky V
    wr_stat(8'h04);
    do_op(3'd4, 2'd2, 2'd0, 32'd0, 32'd0, MD_SO, 1'b1, 8'h00);
    acc_of(2'd2, "R13 collide acc", 64'hFFFF800000000000);
    chk("R13 collide stat", {56'd0, stat}, 64'h00);
    // R7 sticky V clamps an in-range value
    wr_stat(8'h04); op(3'd4, 2'd2, 2'd0, MD_SO);
    acc_of(2'd2, "R7 sticky clamp", 64'hFFFFFFFF80000000);
    chk("R7 sticky stat", {56'd0, stat}, 64'h44);
    // R13 collision with overflowing multiply
    wr_stat(8'h0F);
    do_op(3'd1, 2'd0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, MD_U, 1'b1, 8'h00);
    chk("R13 op over write", {56'd0, stat}, 64'h04);

    // R12 move copies a clear PAV
    wr_stat(8'h10); op(3'd6, 2'd0, 2'd3, MD_U);
    chk("R12 pav clear", {56'd0, stat}, 64'h00);
    acc_of(2'd0, "R12 value2", 64'h0000FFFFFFFFFFFF);

    // R13 sticky hold
    wr_stat(8'h0F); op(3'd3, 2'd1, 2'd0, MD_U);
    @(negedge clk);
    chk("R13 sticky", {56'd0, stat}, 64'h0F);

    finish_run();
  end
endmodule